// File: doc/BRIEF.md
# Capture Interrupt Status Controller

This block collects the events of a two-buffer capture engine and turns them into a single interrupt request. The engine signals a buffer-full pulse for each buffer and an overrun pulse. It also reports the number of records stored so far in each buffer. The block compares each count against a programmable threshold and records a sticky threshold event when the count changes to equal that threshold.

Software uses a small register port to reach the block. It can read the event status, mask events with an enable register, and acknowledge events by writing ones to a clear register. It can also raise any event from software through a set register. The interrupt line is the registered OR of every status bit whose enable bit is set.

Top module: `cap_irq_ctrl`

## Requirements
- R1: After a synchronous reset the status, enable and both threshold registers read 0 and `irq` is 0.
- R2: Register addresses are: 0 status (read only), 1 enable (read/write), 2 clear (write, reads 0), 3 set (write, reads 0), 4 threshold of buffer 0, 5 threshold of buffer 1. `reg_rdata` is registered and shows the value addressed at the previous clock edge.
- R3: Status bit positions are: bit 0 buffer-0 full, bit 1 buffer-1 full, bit 2 buffer-0 threshold, bit 3 buffer-1 threshold, bit 4 overrun. A hardware event sets its bit at the next clock edge. If a hardware event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R4: `irq` is 1 exactly one cycle after some status bit and its matching enable bit are both 1, and 0 one cycle after no such pair exists.
- R5: Writing to the clear register clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: Writing to the set register sets each status bit whose data bit is 1. Data bits above bit 4 are ignored.
- R7: A threshold bit is set only in the cycle in which that buffer's count changes to a value equal to its threshold. A count that stays equal does not set the bit again. Writing a threshold equal to the current, unchanged count does not set the bit.
- R8: A threshold bit stays set when the count moves past the threshold. It is cleared only through the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| full_evt | input | 2 | Buffer-full pulse, one bit per buffer |
| ovr_evt | input | 1 | Overrun pulse |
| buf_cnt | input | 2*CNT_W | Stored-record counts, buffer 0 in the low field |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt path is swept over every combination of five status bits and five enable bits. This separates a mask that gates the wrong bit from a reduction that misses one bit. Each buffer's count is ramped from 0 to 15 against several thresholds. The ramps show whether the compare fires at the equal value, fires early or late, and stays sticky after the count passes the threshold. Further directed patterns hold the count on the threshold, write a threshold equal to an idle count, and collide a hardware event with a clear of the same bit. These tell an edge-triggered compare from a level one and show which of two colliding writes wins.

// File: rtl/cap_irq_pkg.sv
package cap_irq_pkg;
  localparam int NUM_BUF = 2;
  localparam int NUM_EV  = 2 * NUM_BUF + 1;

  // event bit positions
  localparam int FULL_BASE = 0;
  localparam int THR_BASE  = NUM_BUF;
  localparam int OVR_BIT   = 2 * NUM_BUF;

  // register map
  localparam int          ADDR_W     = 3;
  localparam logic [2:0]  ADR_STATUS = 3'd0;
  localparam logic [2:0]  ADR_ENABLE = 3'd1;
  localparam logic [2:0]  ADR_CLEAR  = 3'd2;
  localparam logic [2:0]  ADR_SET    = 3'd3;
  localparam logic [2:0]  ADR_THR0   = 3'd4;
endpackage

// File: rtl/cap_irq_thresh.sv
module cap_irq_thresh #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             hit_o
);
  // previous count, tracked through reset so release never fires spuriously
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_i;
  end

  assign hit_o = (cnt_i != cnt_q) && (cnt_i == thr_i);
endmodule

// File: rtl/cap_irq_regs.sv
module cap_irq_regs
  import cap_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_EV-1:0]                status_i,
  output logic [NUM_EV-1:0]                en_o,
  output logic [NUM_BUF-1:0][CNT_W-1:0]    thr_o,
  output logic [NUM_EV-1:0]                clr_o,
  output logic [NUM_EV-1:0]                set_o,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [NUM_EV-1:0]             en_q;
  logic [NUM_BUF-1:0][CNT_W-1:0] thr_q;
  logic [DATA_W-1:0]             rdata_d;
  logic                          unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:CNT_W];

  assign clr_o = (we_i && addr_i == ADR_CLEAR) ? wdata_i[NUM_EV-1:0] : '0;
  assign set_o = (we_i && addr_i == ADR_SET)   ? wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (we_i && addr_i == ADR_ENABLE) begin
      en_q <= wdata_i[NUM_EV-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_q[b] <= '0;
      end else if (we_i && addr_i == ADR_THR0 + ADDR_W'(b)) begin
        thr_q[b] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADR_STATUS) rdata_d[NUM_EV-1:0] = status_i;
    if (addr_i == ADR_ENABLE) rdata_d[NUM_EV-1:0] = en_q;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (addr_i == ADR_THR0 + ADDR_W'(b)) rdata_d[CNT_W-1:0] = thr_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rdata_d;
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/cap_irq_status.sv
module cap_irq_status
  import cap_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] hw_set_i,
  input  logic [NUM_EV-1:0] sw_set_i,
  input  logic [NUM_EV-1:0] clr_i,
  input  logic [NUM_EV-1:0] en_i,
  output logic [NUM_EV-1:0] status_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] status_q;
  logic [NUM_EV-1:0] status_d;

  // a set of either kind overrides an acknowledge of the same bit
  assign status_d = hw_set_i | sw_set_i | (status_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_o    <= |(status_q & en_i);
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/cap_irq_ctrl.sv
module cap_irq_ctrl
  import cap_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [NUM_BUF-1:0]       full_evt,
  input  logic                     ovr_evt,
  input  logic [NUM_BUF*CNT_W-1:0] buf_cnt,
  output logic                     irq
);
  logic [NUM_EV-1:0]             status_q;
  logic [NUM_EV-1:0]             en_q;
  logic [NUM_EV-1:0]             clr_vec;
  logic [NUM_EV-1:0]             sw_set;
  logic [NUM_EV-1:0]             hw_set;
  logic [NUM_BUF-1:0][CNT_W-1:0] thr;
  logic [NUM_BUF-1:0]            thr_hit;

  cap_irq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .status_i (status_q),
    .en_o     (en_q),
    .thr_o    (thr),
    .clr_o    (clr_vec),
    .set_o    (sw_set),
    .rdata_o  (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    cap_irq_thresh #(.CNT_W(CNT_W)) u_thresh (
      .clk   (clk),
      .cnt_i (buf_cnt[b*CNT_W +: CNT_W]),
      .thr_i (thr[b]),
      .hit_o (thr_hit[b])
    );
    assign hw_set[FULL_BASE + b] = full_evt[b];
    assign hw_set[THR_BASE + b]  = thr_hit[b];
  end
  assign hw_set[OVR_BIT] = ovr_evt;

  cap_irq_status u_status (
    .clk      (clk),
    .rst      (rst),
    .hw_set_i (hw_set),
    .sw_set_i (sw_set),
    .clr_i    (clr_vec),
    .en_i     (en_q),
    .status_o (status_q),
    .irq_o    (irq)
  );
endmodule

// File: rtl/cap_irq_ctrl_chk.sv
module cap_irq_ctrl_chk
  import cap_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_wdata,
  input logic [NUM_BUF-1:0]       full_evt,
  input logic                     ovr_evt,
  input logic [NUM_BUF*CNT_W-1:0] buf_cnt,
  input logic [NUM_EV-1:0]        status,
  input logic [NUM_EV-1:0]        en,
  input logic                     irq
);
  logic clr_wr, set_wr;
  logic unused_chk;
  assign clr_wr = reg_we && reg_addr == ADR_CLEAR;
  assign set_wr = reg_we && reg_addr == ADR_SET;
  assign unused_chk = ^buf_cnt[NUM_BUF*CNT_W-1:CNT_W] ^ full_evt[NUM_BUF-1];

  // R3: hardware events land in their status bit at the next edge
  a_r3_full0_sets: assert property (@(posedge clk) disable iff (rst)
    full_evt[0] |=> status[FULL_BASE]);
  a_r3_ovr_sets: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> status[OVR_BIT]);

  // R4: interrupt follows enabled status one cycle later
  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & en) == '0) |=> !irq);
  a_r4_irq_active: assert property (@(posedge clk) disable iff (rst)
    ((status & en) != '0) |=> irq);

  // R5: acknowledge without a colliding event clears the bit
  a_r5_clear_ovr: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && reg_wdata[OVR_BIT] && !ovr_evt) |=> !status[OVR_BIT]);

  // R7: a steady count cannot raise the threshold bit
  a_r7_no_refire: assert property (@(posedge clk) disable iff (rst)
    ($stable(buf_cnt[CNT_W-1:0]) && !(set_wr && reg_wdata[THR_BASE])
     && !status[THR_BASE]) |=> !status[THR_BASE]);

  // R8: threshold bit holds until acknowledged
  a_r8_thr_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[THR_BASE] && !(clr_wr && reg_wdata[THR_BASE])) |=> status[THR_BASE]);
endmodule

bind cap_irq_ctrl cap_irq_ctrl_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .full_evt  (full_evt),
  .ovr_evt   (ovr_evt),
  .buf_cnt   (buf_cnt),
  .status    (status_q),
  .en        (en_q),
  .irq       (irq)
);

// File: tb/cap_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cap_irq_ctrl_bench;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = 3'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [1:0]        full_evt = 2'b00;
  logic              ovr_evt = 1'b0;
  logic [CNT_W-1:0]  cnt_v [2];
  logic              irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cap_irq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cap_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .full_evt  (full_evt),
    .ovr_evt   (ovr_evt),
    .buf_cnt   ({cnt_v[1], cnt_v[0]}),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [DATA_W-1:0] d;
    cnt_v[0] = '0; cnt_v[1] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(3'd0, d); chk("R1 status", 32'(d), 0);
    rd(3'd1, d); chk("R1 enable", 32'(d), 0);
    rd(3'd4, d); chk("R1 thr0", 32'(d), 0);
    rd(3'd5, d); chk("R1 thr1", 32'(d), 0);

    // R2 readback
    wr(3'd1, 16'h0015); rd(3'd1, d); chk("R2 enable rw", 32'(d), 32'h15);
    wr(3'd4, 16'h00A5); rd(3'd4, d); chk("R2 thr0 rw", 32'(d), 32'hA5);
    wr(3'd5, 16'h003C); rd(3'd5, d); chk("R2 thr1 rw", 32'(d), 32'h3C);
    wr(3'd4, 16'h00FF); wr(3'd5, 16'h00FF);
    wr(3'd1, 16'h0000);

    // R3 hardware event bit positions
    for (int i = 0; i < 3; i++) begin
      wr(3'd2, 16'h001F);
      @(negedge clk);
      if (i < 2) full_evt[i] = 1'b1; else ovr_evt = 1'b1;
      @(negedge clk);
      full_evt = 2'b00; ovr_evt = 1'b0;
      rd(3'd0, d);
      chk("R3 event bit", 32'(d), (i < 2) ? (32'd1 << i) : 32'h10);
    end

    // R3 set beats a same-cycle clear
    wr(3'd2, 16'h001F); wr(3'd3, 16'h0001);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0001; full_evt = 2'b01;
    @(negedge clk);
    reg_we = 1'b0; full_evt = 2'b00;
    rd(3'd0, d); chk("R3 set wins", 32'(d), 32'h01);

    // R5 / R6 clear and set semantics
    wr(3'd3, 16'h001F); wr(3'd2, 16'h0000);
    rd(3'd0, d); chk("R5 zero clear", 32'(d), 32'h1F);
    wr(3'd2, 16'h000A);
    rd(3'd0, d); chk("R5 partial clear", 32'(d), 32'h15);
    rd(3'd2, d); chk("R2 clear reads 0", 32'(d), 0);
    rd(3'd3, d); chk("R2 set reads 0", 32'(d), 0);
    wr(3'd2, 16'h001F); wr(3'd3, 16'hFFE0);
    rd(3'd0, d); chk("R6 upper bits ignored", 32'(d), 0);
    wr(3'd3, 16'h0006);
    rd(3'd0, d); chk("R6 sw set", 32'(d), 32'h06);

    // R4 exhaustive status x enable sweep
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 32; s++) begin
        wr(3'd2, 16'h001F);
        wr(3'd1, 16'(m));
        wr(3'd3, 16'(s));
        @(negedge clk);
        chk("R4 irq", 32'(irq), ((s & m) != 0) ? 1 : 0);
      end
    end
    wr(3'd1, 16'h0000); wr(3'd2, 16'h001F);
    @(negedge clk); @(negedge clk);
    chk("R4 irq drops", 32'(irq), 0);

    // R7 / R8 threshold ramps on both buffers
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 4; k++) begin
        automatic int t = (k == 0) ? 1 : (k == 1) ? 4 : (k == 2) ? 9 : 15;
        @(negedge clk); cnt_v[b] = '0;
        wr(3'(4 + b), 16'(t));
        wr(3'd2, 16'h001F);
        for (int v = 1; v < 16; v++) begin
          @(negedge clk); cnt_v[b] = 8'(v); reg_addr = 3'd0;
          @(negedge clk); @(negedge clk);
          chk((v > t) ? "R8 sticky" : "R7 ramp", 32'(reg_rdata[2+b]), (v >= t) ? 1 : 0);
        end
      end
      // R7 held count does not refire
      @(negedge clk); cnt_v[b] = 8'd3;
      wr(3'(4 + b), 16'd3);
      wr(3'd2, 16'h001F);
      repeat (4) @(negedge clk);
      rd(3'd0, d); chk("R7 hold no refire", 32'(d[2+b]), 0);
      // R7 threshold written equal to idle count
      @(negedge clk); cnt_v[b] = 8'd6;
      wr(3'd2, 16'h001F);
      wr(3'(4 + b), 16'd6);
      repeat (3) @(negedge clk);
      rd(3'd0, d); chk("R7 thr write no fire", 32'(d[2+b]), 0);
      @(negedge clk); cnt_v[b] = 8'd7;
      @(negedge clk); cnt_v[b] = 8'd6;
      rd(3'd0, d); chk("R7 return fires", 32'(d[2+b]), 1);
      wr(3'd2, 16'(1 << (2 + b)));
      rd(3'd0, d); chk("R8 cleared by ack", 32'(d[2+b]), 0);
      @(negedge clk); cnt_v[b] = '0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule